// File: doc/BRIEF.md
# Staged Register-Fronted RAM with Split Row/Column Select

This block is a small word-addressed RAM. No caller ever touches a storage cell directly. Every access goes through an address holding register and a data holding register, and it moves through fixed steps, one step per clock.

A fetch takes three steps:
- latch the address;
- decode it;
- copy the selected word into the data register.

A store takes four steps:
- latch the address;
- latch the value;
- decode the address;
- write the data register into the selected word.

The latched address is split into an upper half and a lower half. Each half drives its own one-hot decoder, one for rows and one for columns. A cell is chosen where its row line and its column line are both high. This needs only 2·2^(N/2) select lines, not 2^N.

A caller puts a command on `cmd` for one cycle while `busy` is low. For a store, it puts the value on `data_in` in the following cycle. It then waits for the one-cycle `done` pulse. The `data_out` port always shows the data register. The `read_only` input is sampled when a command is accepted. When it is high, stores run their full sequence but leave the array untouched. The two select vectors are brought out so that an integrator can watch the decode step.

Top module: `mar_mdr_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, addressed 0 to 2^ADDR_W−1. A word stored at any address, including 0 and the highest address, is returned by a later fetch of that address.
- R2: A fetch accepted at clock edge A raises `done` right after the second edge following A, with the fetched word on `data_out`. The latency is the same for every address.
- R3: A store accepted at edge A samples `data_in` at the next edge and raises `done` right after the third edge following A. At that point `data_out` shows the stored value.
- R4: The `cmd` encoding is: 2'b01 = fetch, 2'b10 = store, 2'b00 and 2'b11 = no operation. A no-operation code never raises `busy` or `done`.
- R5: When `done` is high, `row_sel` has exactly one bit set, at index addr[ADDR_W-1:ADDR_W/2]. `col_sel` has exactly one bit set, at index addr[ADDR_W/2-1:0]. Neither vector ever has more than one bit set.
- R6: A store accepted while `read_only` is high leaves the array unchanged. A fetch with `read_only` high works normally.
- R7: `busy` is high from the cycle after acceptance until `done`. Commands presented while `busy` is high are ignored and do not change the array.
- R8: `done` is high for exactly one cycle per operation.
- R9: After an operation, `data_out` holds its value until the next operation loads the data register again.
- R10: A synchronous reset clears the address register, the data register, both select vectors, `busy` and `done`. It leaves the array contents unchanged. ADDR_W must be even, which is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Command: 01 fetch, 10 store, else none |
| addr_in | input | ADDR_W | Address, sampled when a command is accepted |
| data_in | input | DATA_W | Store value, sampled one cycle after acceptance |
| read_only | input | 1 | Blocks array writes for the accepted store |
| data_out | output | DATA_W | Contents of the data register |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| row_sel | output | 2^(ADDR_W/2) | One-hot row select |
| col_sel | output | 2^(ADDR_W/2) | One-hot column select |

## Verification
The bench targets the extreme addresses, where a swapped or mis-sliced address half would hit the wrong crossing and corrupt a neighbouring word. It also issues a store that collides with a busy sequence, which a design that fails to ignore commands while busy would let overwrite another cell. A read-only store is followed by a fetch, which exposes any write that slips through. A reset is dropped in the middle of a store, where a design that clears the array, or that finishes the write anyway, returns the wrong word afterwards. Exact `done` latencies catch any skipped or extra step.

// File: rtl/mar_mdr_ram.sv
`timescale 1ns/1ps
module mar_mdr_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   cmd,
  input  logic [ADDR_W-1:0]            addr_in,
  input  logic [DATA_W-1:0]            data_in,
  input  logic                         read_only,
  output logic [DATA_W-1:0]            data_out,
  output logic                         busy,
  output logic                         done,
  output logic [(1<<(ADDR_W/2))-1:0]   row_sel,
  output logic [(1<<(ADDR_W/2))-1:0]   col_sel
);
  localparam int HALF = ADDR_W / 2;
  localparam int SIDE = 1 << HALF;

  if (ADDR_W % 2 != 0) begin : g_bad_width
    $error("ADDR_W must be even");
  end

  typedef enum logic [1:0] {S_IDLE, S_LDDATA, S_DECODE, S_XFER} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   mar;
  logic [DATA_W-1:0]   mdr;
  logic                is_store;
  logic                wr_ok;
  logic [SIDE-1:0]     row_dec, col_dec;
  logic [DATA_W-1:0]   cell_q;
  logic [DATA_W-1:0]   mem [SIDE][SIDE];

  wire start = (state == S_IDLE) && (cmd == 2'b01 || cmd == 2'b10);

  assign row_dec  = SIDE'(1) << mar[ADDR_W-1:HALF];
  assign col_dec  = SIDE'(1) << mar[HALF-1:0];
  assign data_out = mdr;
  assign busy     = (state != S_IDLE);

  always_comb begin
    cell_q = '0;
    for (int r = 0; r < SIDE; r++)
      for (int c = 0; c < SIDE; c++)
        if (row_sel[r] && col_sel[c]) cell_q = cell_q | mem[r][c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mar      <= '0;
      mdr      <= '0;
      is_store <= 1'b0;
      wr_ok    <= 1'b0;
      row_sel  <= '0;
      col_sel  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mar      <= addr_in;
          is_store <= (cmd == 2'b10);
          wr_ok    <= (cmd == 2'b10) && !read_only;
          state    <= (cmd == 2'b10) ? S_LDDATA : S_DECODE;
        end
        S_LDDATA: begin
          mdr   <= data_in;
          state <= S_DECODE;
        end
        S_DECODE: begin
          row_sel <= row_dec;
          col_sel <= col_dec;
          state   <= S_XFER;
        end
        default: begin
          if (!is_store) mdr <= cell_q;
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      always_ff @(posedge clk)
        if (!rst && state == S_XFER && wr_ok && row_sel[r] && col_sel[c])
          mem[r][c] <= mdr;
    end
  end
endmodule

module mar_mdr_ram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0]                  cmd,
  input logic                        busy,
  input logic                        done,
  input logic [DATA_W-1:0]           data_out,
  input logic [ADDR_W-1:0]           mar,
  input logic [(1<<(ADDR_W/2))-1:0]  row_sel,
  input logic [(1<<(ADDR_W/2))-1:0]  col_sel
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  sel_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($onehot(row_sel) && $onehot(col_sel)));
  // R5
  sel_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel) && $onehot0(col_sel));
  // R7
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(mar));
  // R9
  mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd != 2'b01 && cmd != 2'b10) |=> $stable(data_out));
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy));
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && data_out == '0 && row_sel == '0 && col_sel == '0));
endmodule

bind mar_mdr_ram mar_mdr_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cmd(cmd), .busy(busy), .done(done), .data_out(data_out),
  .mar(mar), .row_sel(row_sel), .col_sel(col_sel)
);

// File: tb/mar_mdr_ram_tb_top.sv
`timescale 1ns/1ps
module mar_mdr_ram_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int H  = AW / 2;
  localparam int SD = 1 << H;

  logic clk = 0, rst = 1, ro = 0;
  logic [1:0] cmd = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0, dout;
  logic busy, done;
  logic [SD-1:0] row_sel, col_sel;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [1<<AW];

  always #2.5 clk = ~clk;

  mar_mdr_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .addr_in(addr), .data_in(wdata), .read_only(ro),
    .data_out(dout), .busy(busy), .done(done), .row_sel(row_sel), .col_sel(col_sel));

  function automatic logic [SD-1:0] exp_row(input logic [AW-1:0] a);
    return SD'(1) << a[AW-1:H];
  endfunction
  function automatic logic [SD-1:0] exp_col(input logic [AW-1:0] a);
    return SD'(1) << a[H-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic r, input bit intrude, input string req);
    int n;
    @(negedge clk); cmd = c; addr = a; ro = r; wdata = d;
    @(negedge clk); cmd = 0; ro = 0;
    check(busy === 1'b1, "R7", "busy after accept", 32'(busy), 1);
    n = 1;
    while (done !== 1'b1 && n < 12) begin
      if (intrude && n == 1) begin cmd = 2'b10; addr = ~a; end
      else cmd = 0;
      @(negedge clk); n++;
    end
    cmd = 0;
    if (c == 2'b01) begin
      check(n == 3, "R2", "fetch latency", 32'(n), 3);
      check(dout === model[a], req, "fetched word", 32'(dout), 32'(model[a]));
    end else begin
      check(n == 4, "R3", "store latency", 32'(n), 4);
      check(dout === d, "R3", "data reg after store", 32'(dout), 32'(d));
      if (!r) model[a] = d;
    end
    check(row_sel === exp_row(a), "R5", "row select", 32'(row_sel), 32'(exp_row(a)));
    check(col_sel === exp_col(a), "R5", "col select", 32'(col_sel), 32'(exp_col(a)));
    @(negedge clk);
    check(done === 1'b0, "R8", "done width", 32'(done), 0);
  endtask

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && dout === '0, "R10", "reset state", 32'(dout), 0);
    rst = 0;

    for (int i = 0; i < (1 << AW); i++) run_op(2'b10, AW'(i), DW'($urandom), 0, 0, "R1");
    run_op(2'b01, '0, 0, 0, 0, "R1");
    run_op(2'b01, '1, 0, 0, 0, "R1");
    run_op(2'b10, '1, 16'hA5C3, 0, 0, "R1");
    run_op(2'b01, '1, 0, 0, 0, "R1");

    // R4: code 11 and 00 are no-ops
    @(negedge clk); cmd = 2'b11; addr = 5;
    @(negedge clk); cmd = 0;
    check(busy === 1'b0 && done === 1'b0, "R4", "no-op code 11", 32'({busy, done}), 0);
    @(negedge clk);
    check(done === 1'b0, "R4", "no done after 11", 32'(done), 0);

    // R6: read-only store
    run_op(2'b10, 6'd9, 16'hDEAD, 1, 0, "R6");
    run_op(2'b01, 6'd9, 0, 1, 0, "R6");

    // R7: colliding store while busy
    run_op(2'b10, 6'd12, 16'h1234, 0, 1, "R7");
    run_op(2'b01, ~6'd12, 0, 0, 0, "R7");
    run_op(2'b01, 6'd12, 0, 0, 0, "R7");

    // R9: data register holds
    held = dout;
    repeat (4) begin
      @(negedge clk); addr = AW'($urandom); wdata = DW'($urandom);
    end
    check(dout === held, "R9", "data register hold", 32'(dout), 32'(held));

    // R10: reset mid-store, array kept
    @(negedge clk); cmd = 2'b10; addr = 6'd20; wdata = 16'hBEEF;
    @(negedge clk); cmd = 0; rst = 1;
    @(negedge clk);
    check(busy === 0 && dout === '0 && row_sel === '0 && col_sel === '0, "R10",
          "reset clears", 32'(dout), 0);
    rst = 0;
    run_op(2'b01, 6'd20, 0, 0, 0, "R10");
    run_op(2'b01, 6'd33, 0, 0, 0, "R10");

    for (int k = 0; k < 300; k++) begin
      if ($urandom % 2) run_op(2'b01, AW'($urandom), 0, ($urandom % 4 == 0), 0, "R1");
      else run_op(2'b10, AW'($urandom), DW'($urandom), ($urandom % 8 == 0), 0, "R6");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule